// File: doc/BRIEF.md
# Fan Speed Sequencer with Kickstart

This block turns a small speed code into the drive pattern for a fan: a group of active-low speed-select lines and one enable line that is low while the fan is shut down. Code zero means the fan is off. Any other code selects a speed, and the select lines carry the bitwise inverse of that code.

A fan that starts at a low speed may stall. So whenever the code leaves zero, the block first runs the fan at full speed for one start interval and only then applies the programmed speed. The block also staggers the two kinds of line. At start, the select lines move first and the enable follows half an interval later. At stop, the enable drops first and the select lines return to idle half an interval later. Time is counted in pulses of a tick enable that comes from a slow local oscillator. The block raises a request for that oscillator only while a timed phase is running, so the oscillator can be stopped when idle.

The code input is expected to come from a register elsewhere. The block acts only while its fan-mode input is high. All outputs are registered and follow their inputs with one clock of latency.

Top module: `fan_kick_seq`

## Requirements
- R1: After reset, while fan mode is low, and once a stop has completed, the select lines are all ones and the enable is 0.
- R2: Outside the timed phases, with a nonzero code, the select lines equal the bitwise inverse of the code and the enable is 1. A change from one nonzero code to another takes effect one clock later, with no kick.
- R3: When the code changes from zero to nonzero, the select lines go to all zeros for START_TICKS tick pulses in total. After that they show the inverse of the current code.
- R4: At start, the enable stays 0 until HALF = START_TICKS/2 ticks after the select lines reached all zeros, and then rises while the lines are still all zeros.
- R5: When the code becomes zero from a running or kicking state, the enable drops in the next clock and the select lines hold their pattern. After HALF ticks they return to all ones.
- R6: The oscillator request is high only during the kick and the stop delay, and the interval counter does not move while it is low.
- R7: A zero code written during the kick starts the stop sequence at once.
- R8: A nonzero code written during the stop delay starts a new full kick, and the count restarts from zero.
- R9: Low fan mode sends the block to the idle state one clock later. When fan mode rises again with a nonzero code, a kick starts.
- R10: Only clocks with tick_en high advance the interval. The tick in the clock that enters a timed phase is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fan_mode | input | 1 | Enables the sequencer; low forces idle |
| tick_en | input | 1 | Timebase pulse from the local oscillator |
| speed_code | input | CODE_W | Programmed speed, zero means off |
| spd_n | output | CODE_W | Active-low speed-select lines |
| fan_en | output | 1 | Fan enable, 0 = shut down |
| osc_run | output | 1 | Request to keep the local oscillator running |

## Verification
The embedded properties check, on every clock, the relations that hold no matter how long a phase lasts. Idle always shows all ones with the enable low. The enable is never high during a timed phase unless the lines are all zeros. The enable rises only from an all-zero pattern and falls with the pattern held. While running, the output is the inverse of the code. The counter is frozen whenever the oscillator request is low. How long each phase lasts cannot be seen by these properties, and neither can the reactions to a zero code in mid-kick, to a nonzero code in mid-stop, to sparse ticks, or to fan mode dropping. The bench scenarios show these by comparing every clock against a tick-counting reference model.

// File: rtl/fan_seq_pkg.sv
package fan_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_KICK_LO,
    ST_KICK_HI,
    ST_RUN,
    ST_STOP
  } fan_state_t;
endpackage

// File: rtl/fan_code_map.sv
module fan_code_map #(
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] pat_n,
  output logic              nonzero
);
  // each select line is the inverse of its code bit
  for (genvar g = 0; g < CODE_W; g++) begin : g_bit
    assign pat_n[g] = ~code[g];
  end
  assign nonzero = |code;
endmodule

// File: rtl/fan_tick_timer.sv
module fan_tick_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = adv && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (adv)   cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
  end

  AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(cnt_q)); // R6

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && limit != '0) |-> (cnt_q < limit)); // R10
endmodule

// File: rtl/fan_seq_ctrl.sv
module fan_seq_ctrl
  import fan_seq_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int START_TICKS = 32768,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fan_mode,
  input  logic              tick_en,
  input  logic              code_nz,
  input  logic [CODE_W-1:0] pat_n,
  input  logic              tmr_done,
  output logic              tmr_clr,
  output logic              tmr_adv,
  output logic [CNT_W-1:0]  tmr_limit,
  output logic [CODE_W-1:0] spd_n,
  output logic              fan_en,
  output logic              osc_run
);
  localparam int HALF = START_TICKS / 2;
  localparam int REST = START_TICKS - HALF;

  fan_state_t state_q, state_d;
  logic [CODE_W-1:0] spd_q, spd_d;
  logic en_q, en_d, osc_q, osc_d;
  logic timed;

  assign timed     = (state_q == ST_KICK_LO) || (state_q == ST_KICK_HI) || (state_q == ST_STOP);
  assign tmr_adv   = tick_en && timed;
  assign tmr_limit = (state_q == ST_KICK_HI) ? CNT_W'(REST) : CNT_W'(HALF);

  always_comb begin
    state_d = state_q;
    tmr_clr = 1'b0;
    unique case (state_q)
      ST_OFF: if (code_nz) begin state_d = ST_KICK_LO; tmr_clr = 1'b1; end
      ST_KICK_LO: begin
        if (!code_nz)      begin state_d = ST_STOP;    tmr_clr = 1'b1; end
        else if (tmr_done) begin state_d = ST_KICK_HI; tmr_clr = 1'b1; end
      end
      ST_KICK_HI: begin
        if (!code_nz)      begin state_d = ST_STOP; tmr_clr = 1'b1; end
        else if (tmr_done) begin state_d = ST_RUN;  tmr_clr = 1'b1; end
      end
      ST_RUN: if (!code_nz) begin state_d = ST_STOP; tmr_clr = 1'b1; end
      ST_STOP: begin
        if (code_nz)       begin state_d = ST_KICK_LO; tmr_clr = 1'b1; end
        else if (tmr_done) begin state_d = ST_OFF;     tmr_clr = 1'b1; end
      end
      default: begin state_d = ST_OFF; tmr_clr = 1'b1; end
    endcase
    if (!fan_mode) begin
      state_d = ST_OFF;
      tmr_clr = 1'b1;
    end
  end

  always_comb begin
    spd_d = '1;
    en_d  = 1'b0;
    unique case (state_d)
      ST_KICK_LO: spd_d = '0;
      ST_KICK_HI: begin spd_d = '0; en_d = 1'b1; end
      ST_RUN:     begin spd_d = pat_n; en_d = 1'b1; end
      ST_STOP:    spd_d = spd_q;
      default:    spd_d = '1;
    endcase
    osc_d = (state_d == ST_KICK_LO) || (state_d == ST_KICK_HI) || (state_d == ST_STOP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      spd_q   <= '1;
      en_q    <= 1'b0;
      osc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      spd_q   <= spd_d;
      en_q    <= en_d;
      osc_q   <= osc_d;
    end
  end

  assign spd_n   = spd_q;
  assign fan_en  = en_q;
  assign osc_run = osc_q;

  AST_IDLE_PATTERN: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !osc_q) |-> (spd_q == '1)); // R1

  AST_KICK_FULL: assert property (@(posedge clk) disable iff (rst)
    (en_q && osc_q) |-> (spd_q == '0)); // R3

  AST_START_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> ($past(spd_q) == '0 && spd_q == '0)); // R4

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($fell(en_q) && $past(fan_mode)) |-> $stable(spd_q)); // R5
endmodule

// File: rtl/fan_kick_seq.sv
module fan_kick_seq #(
  parameter int CODE_W      = 3,
  parameter int START_TICKS = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fan_mode,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] speed_code,
  output logic [CODE_W-1:0] spd_n,
  output logic              fan_en,
  output logic              osc_run
);
  localparam int CNT_W = $clog2(START_TICKS + 1);

  logic [CODE_W-1:0] pat_n;
  logic code_nz, tmr_clr, tmr_adv, tmr_done;
  logic [CNT_W-1:0] tmr_limit;

  fan_code_map #(.CODE_W(CODE_W)) u_map (
    .code(speed_code), .pat_n(pat_n), .nonzero(code_nz)
  );

  fan_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .adv(tmr_adv),
    .limit(tmr_limit), .done(tmr_done)
  );

  fan_seq_ctrl #(.CODE_W(CODE_W), .START_TICKS(START_TICKS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .fan_mode(fan_mode), .tick_en(tick_en),
    .code_nz(code_nz), .pat_n(pat_n), .tmr_done(tmr_done),
    .tmr_clr(tmr_clr), .tmr_adv(tmr_adv), .tmr_limit(tmr_limit),
    .spd_n(spd_n), .fan_en(fan_en), .osc_run(osc_run)
  );

  AST_RUN_MAP: assert property (@(posedge clk) disable iff (rst)
    (fan_en && !osc_run) |-> (spd_n == ~$past(speed_code))); // R2
endmodule

// File: tb/tb_fan_kick_seq.sv
module tb_fan_kick_seq;
  localparam int CW = 3;
  localparam int ST = 8;
  localparam int HF = ST / 2;

  logic clk = 1'b0, rst = 1'b1, fan_mode = 1'b0, tick_en = 1'b0;
  logic [CW-1:0] speed_code = '0;
  logic [CW-1:0] spd_n;
  logic fan_en, osc_run;

  fan_kick_seq #(.CODE_W(CW), .START_TICKS(ST)) dut (
    .clk(clk), .rst(rst), .fan_mode(fan_mode), .tick_en(tick_en),
    .speed_code(speed_code), .spd_n(spd_n), .fan_en(fan_en), .osc_run(osc_run)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, tick_div = 1;
  string req = "R1";
  bit finished = 1'b0;

  // reference model: phase 0 idle, 1 kicking, 2 running, 3 stopping
  int ph = 0, kick_cnt = 0, stop_cnt = 0;
  logic [CW-1:0] e_spd = '1;
  logic e_en = 1'b0, e_osc = 1'b0;

  always @(posedge clk) begin
    if (rst || !fan_mode) begin
      ph = 0; kick_cnt = 0; stop_cnt = 0;
    end else begin
      case (ph)
        0: if (speed_code != 0) begin ph = 1; kick_cnt = 0; end
        1: if (speed_code == 0) begin ph = 3; stop_cnt = 0; end
           else if (tick_en) begin
             kick_cnt++;
             if (kick_cnt == ST) ph = 2;
           end
        2: if (speed_code == 0) begin ph = 3; stop_cnt = 0; end
        3: if (speed_code != 0) begin ph = 1; kick_cnt = 0; end
           else if (tick_en) begin
             stop_cnt++;
             if (stop_cnt == HF) ph = 0;
           end
        default: ph = 0;
      endcase
    end
    case (ph)
      0: begin e_spd = '1; e_en = 1'b0; end
      1: begin e_spd = '0; e_en = (kick_cnt >= HF); end
      2: begin e_spd = ~speed_code; e_en = 1'b1; end
      default: e_en = 1'b0;
    endcase
    e_osc = (ph == 1) || (ph == 3);
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (spd_n !== e_spd || fan_en !== e_en || osc_run !== e_osc) begin
        errors++;
        $display("FAIL %s cycle %0d: actual spd_n=%b fan_en=%b osc_run=%b expected spd_n=%b fan_en=%b osc_run=%b",
                 req, cyc, spd_n, fan_en, osc_run, e_spd, e_en, e_osc);
      end
      cyc++;
      tick_en = ((cyc % tick_div) == 0);
    end
  endtask

  initial begin
    req = "R1"; step(3);
    rst = 1'b0; fan_mode = 1'b1; step(3);
    req = "R3"; speed_code = 3'd2; step(3);
    req = "R4"; step(10);
    req = "R2"; speed_code = 3'd5; step(3);
    speed_code = 3'd7; step(2);
    speed_code = 3'd1; step(2);
    req = "R5"; speed_code = 3'd0; step(8);
    req = "R7"; speed_code = 3'd3; step(2);
    speed_code = 3'd0; step(7);
    speed_code = 3'd3; step(6);
    speed_code = 3'd0; step(8);
    req = "R8"; speed_code = 3'd4; step(11);
    speed_code = 3'd0; step(2);
    speed_code = 3'd6; step(12);
    speed_code = 3'd0; step(7);
    req = "R10"; tick_div = 3; speed_code = 3'd1; step(32);
    speed_code = 3'd0; step(16);
    tick_div = 1;
    req = "R9"; speed_code = 3'd5; step(10);
    fan_mode = 1'b0; step(3);
    fan_mode = 1'b1; step(12);
    speed_code = 3'd0; step(8);
    req = "R6"; step(6);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog in %s: actual run not finished, expected completion", req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule